// File: doc/BRIEF.md
# Opcode to Machine-Cycle Decoder

This block turns one 8-bit opcode of a simple 8-bit processor into the ordered list of machine cycles that the sequencer must run for it. Each list entry, a machine-cycle descriptor, names a bus operation and, optionally, a register-transfer operation that the datapath performs while the bus operation runs. The bus operation is an opcode fetch, a memory read or a memory write from a named address source, or an internal cycle of a given length. The transfer is none, an 8-bit move, an 8-bit add, a 16-bit move or a 16-bit add.

The decoder splits the opcode into three fields (x = bits 7:6, y = bits 5:3, z = bits 2:0) and classifies it into one of the supported groups: no-op, 8-bit immediate load, 16-bit immediate load, add of a pair to HL, register and memory moves, halt, accumulator add and absolute jump. The lists always close with the fetch of the next opcode, so a transfer placed in the last slot overlaps that fetch. The sequencer presents an opcode with a strobe and picks the decoded list up one clock later. It also gets the count of valid slots, a halt marker and a flag for opcodes outside the supported groups.

Top module: `opcode_mcycle_decoder`

## Requirements
- R1: One clock after `op_valid` is sampled high, `dec_valid` is high and the outputs hold the decode of the sampled `opcode`. One clock after `op_valid` is sampled low, `dec_valid` is low.
- R2: While `op_valid` is low, `dec_count`, `dec_slots`, `dec_unsup` and `dec_halt` keep their values.
- R3: While `rst_n` is low (asynchronous, active low), every output is zero.
- R4: Slot k sits at `dec_slots[k*19 +: 19]`, laid out as bus[18:17] (0 fetch, 1 read, 2 write, 3 internal), addr[16:15] (0 none, 1 PC, 2 HL), len[14:12], op[11:9] (0 none, 1 move8, 2 add8, 3 move16, 4 add16), dst[8:6], srcA[5:3], srcB[2:0]. A fetch carries addr 1. An internal cycle carries addr 0 and its length. Reads and writes carry len 0. Unused operand fields are 0. 8-bit codes are 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory latch, 7 A. 16-bit codes are 0 BC, 1 DE, 2 HL, 3 SP, 4 PC, 5 latch pair, and an opcode pair field p = y>>1 uses codes 0 to 3. The count is 1 to 5. The slot at index count-1 is a fetch, and every slot at or above the count is all zero.
- R5: Opcode 0x00 decodes as one plain fetch. Any opcode outside the groups of R6 to R11 also decodes as one plain fetch, with `dec_unsup` high. `dec_unsup` is low for every supported opcode.
- R6: x=0, z=6, y≠6 gives [read PC, fetch+move8(y←6)]. Opcode 0x36 gives [read PC, write HL, fetch].
- R7: x=0, z=1, y even gives [read PC, read PC, fetch+move16(p←5)]. With y odd it gives [internal len 4, internal len 3, fetch+add16(2←2,p)].
- R8: For x=1 other than 0x76: with z=6 it gives [read HL, fetch+move8(y←6)]. With y=6 it gives [write HL+move8(6←z), fetch]. Any other combination gives [fetch+move8(y←z)].
- R9: Opcode 0x76 gives one plain fetch with `dec_halt` high and `dec_unsup` low. `dec_halt` is low for every other opcode.
- R10: x=2, y=0 gives [fetch+add8(7←7,z)] for z≠6 and [read HL, fetch+add8(7←7,6)] for z=6. Opcode 0xC6 gives [read PC, fetch+add8(7←7,6)].
- R11: Opcode 0xC3 gives [read PC, read PC, fetch+move16(4←5)].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Opcode strobe |
| opcode | input | 8 | Opcode to decode |
| dec_valid | output | 1 | Decoded list is fresh this cycle |
| dec_count | output | 3 | Number of valid slots |
| dec_unsup | output | 1 | Opcode outside the supported groups |
| dec_halt | output | 1 | Opcode is the halt instruction |
| dec_slots | output | 95 | Five 19-bit machine-cycle descriptors, slot 0 lowest |

## Verification
The assertions assume that `opcode` is settled whenever `op_valid` is sampled high. They do not assume anything about how strobes are spaced, because the decoder keeps no state across opcodes. The stimulus changes inputs only on the falling clock edge. It walks all 256 opcodes, mostly in back-to-back strobes, and inserts idle cycles in which `opcode` is changed to an unrelated value, so that any leak of the input into the held outputs shows up.

// File: rtl/odec_pkg.sv
package odec_pkg;

  localparam int BUS_W  = 2;
  localparam int ADR_W  = 2;
  localparam int LEN_W  = 3;
  localparam int ALU_W  = 3;
  localparam int REG_W  = 3;
  localparam int DESC_W = BUS_W + ADR_W + LEN_W + ALU_W + 3 * REG_W;

  typedef enum logic [BUS_W-1:0] {
    BUS_FETCH = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2,
    BUS_IDLE  = 2'd3
  } bus_e;

  typedef enum logic [ADR_W-1:0] {
    ADR_NONE = 2'd0,
    ADR_PC   = 2'd1,
    ADR_HL   = 2'd2
  } adr_e;

  typedef enum logic [ALU_W-1:0] {
    XF_NONE  = 3'd0,
    XF_MOV8  = 3'd1,
    XF_ADD8  = 3'd2,
    XF_MOV16 = 3'd3,
    XF_ADD16 = 3'd4
  } xfer_e;

  typedef enum logic [3:0] {
    GRP_NOP,
    GRP_LDI8,
    GRP_LDI8M,
    GRP_LDI16,
    GRP_ADD16,
    GRP_HALT,
    GRP_LDRM,
    GRP_LDMR,
    GRP_LDRR,
    GRP_ADDR,
    GRP_ADDM,
    GRP_ADDI,
    GRP_JUMP,
    GRP_BAD
  } grp_e;

  typedef struct packed {
    bus_e             bus;
    adr_e             adr;
    logic [LEN_W-1:0] len;
    xfer_e            xf;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] sa;
    logic [REG_W-1:0] sb;
  } mdesc_t;

  // register codes that the datapath decodes
  localparam logic [REG_W-1:0] R8_LATCH  = 3'd6;
  localparam logic [REG_W-1:0] R8_ACC    = 3'd7;
  localparam logic [REG_W-1:0] R16_HL    = 3'd2;
  localparam logic [REG_W-1:0] R16_PC    = 3'd4;
  localparam logic [REG_W-1:0] R16_LATCH = 3'd5;

  localparam mdesc_t DESC_ZERO = '0;

  function automatic mdesc_t fetch_d(xfer_e xf, logic [REG_W-1:0] dst,
                                     logic [REG_W-1:0] sa, logic [REG_W-1:0] sb);
    mdesc_t d;
    d     = DESC_ZERO;
    d.bus = BUS_FETCH;
    d.adr = ADR_PC;
    d.xf  = xf;
    d.dst = dst;
    d.sa  = sa;
    d.sb  = sb;
    return d;
  endfunction

  function automatic mdesc_t read_d(adr_e adr);
    mdesc_t d;
    d     = DESC_ZERO;
    d.bus = BUS_READ;
    d.adr = adr;
    return d;
  endfunction

  function automatic mdesc_t write_d(adr_e adr, xfer_e xf,
                                     logic [REG_W-1:0] dst, logic [REG_W-1:0] sa);
    mdesc_t d;
    d     = DESC_ZERO;
    d.bus = BUS_WRITE;
    d.adr = adr;
    d.xf  = xf;
    d.dst = dst;
    d.sa  = sa;
    return d;
  endfunction

  function automatic mdesc_t idle_d(logic [LEN_W-1:0] len);
    mdesc_t d;
    d     = DESC_ZERO;
    d.bus = BUS_IDLE;
    d.len = len;
    return d;
  endfunction

  function automatic mdesc_t plain_fetch();
    return fetch_d(XF_NONE, '0, '0, '0);
  endfunction

endpackage

// File: rtl/odec_fields.sv
module odec_fields (
  input  logic [7:0] opcode,
  output logic [1:0] fx,
  output logic [2:0] fy,
  output logic [2:0] fz,
  output logic [1:0] fpair,
  output logic       fy_odd
);
  assign fx     = opcode[7:6];
  assign fy     = opcode[5:3];
  assign fz     = opcode[2:0];
  assign fpair  = opcode[5:4];
  assign fy_odd = opcode[3];
endmodule

// File: rtl/odec_group.sv
module odec_group
  import odec_pkg::*;
(
  input  logic [1:0] fx,
  input  logic [2:0] fy,
  input  logic [2:0] fz,
  input  logic       fy_odd,
  output grp_e       grp
);
  localparam logic [2:0] MEM_CODE = 3'd6;

  always_comb begin
    grp = GRP_BAD;
    unique case (fx)
      2'd0: begin
        if (fy == 3'd0 && fz == 3'd0)         grp = GRP_NOP;
        else if (fz == MEM_CODE)              grp = (fy == MEM_CODE) ? GRP_LDI8M : GRP_LDI8;
        else if (fz == 3'd1)                  grp = fy_odd ? GRP_ADD16 : GRP_LDI16;
        else                                  grp = GRP_BAD;
      end
      2'd1: begin
        if (fy == MEM_CODE && fz == MEM_CODE) grp = GRP_HALT;
        else if (fz == MEM_CODE)              grp = GRP_LDRM;
        else if (fy == MEM_CODE)              grp = GRP_LDMR;
        else                                  grp = GRP_LDRR;
      end
      2'd2: begin
        if (fy != 3'd0)                       grp = GRP_BAD;
        else if (fz == MEM_CODE)              grp = GRP_ADDM;
        else                                  grp = GRP_ADDR;
      end
      default: begin
        if (fy == 3'd0 && fz == 3'd3)         grp = GRP_JUMP;
        else if (fy == 3'd0 && fz == MEM_CODE) grp = GRP_ADDI;
        else                                  grp = GRP_BAD;
      end
    endcase
  end
endmodule

// File: rtl/odec_seq.sv
module odec_seq
  import odec_pkg::*;
#(
  parameter int MAX_SLOTS = 5,
  parameter int IDLE_LEN_A = 4,
  parameter int IDLE_LEN_B = 3,
  localparam int CNT_W = $clog2(MAX_SLOTS + 1),
  localparam int LIST_N = 3
) (
  input  grp_e                        grp,
  input  logic [2:0]                  fy,
  input  logic [2:0]                  fz,
  input  logic [1:0]                  fpair,
  output mdesc_t [MAX_SLOTS-1:0]      slots,
  output logic   [CNT_W-1:0]          count,
  output logic                        unsup,
  output logic                        halt
);
  mdesc_t [LIST_N-1:0] list;
  logic   [1:0]        list_len;
  logic   [REG_W-1:0]  pair_code;

  assign pair_code = {1'b0, fpair};

  always_comb begin
    list     = '0;
    list_len = 2'd1;
    unsup    = 1'b0;
    halt     = 1'b0;
    list[0]  = plain_fetch();
    unique case (grp)
      GRP_NOP: ;
      GRP_LDI8: begin
        list[0]  = read_d(ADR_PC);
        list[1]  = fetch_d(XF_MOV8, fy, R8_LATCH, '0);
        list_len = 2'd2;
      end
      GRP_LDI8M: begin
        list[0]  = read_d(ADR_PC);
        list[1]  = write_d(ADR_HL, XF_NONE, '0, '0);
        list[2]  = plain_fetch();
        list_len = 2'd3;
      end
      GRP_LDI16: begin
        list[0]  = read_d(ADR_PC);
        list[1]  = read_d(ADR_PC);
        list[2]  = fetch_d(XF_MOV16, pair_code, R16_LATCH, '0);
        list_len = 2'd3;
      end
      GRP_ADD16: begin
        list[0]  = idle_d(LEN_W'(IDLE_LEN_A));
        list[1]  = idle_d(LEN_W'(IDLE_LEN_B));
        list[2]  = fetch_d(XF_ADD16, R16_HL, R16_HL, pair_code);
        list_len = 2'd3;
      end
      GRP_HALT: halt = 1'b1;
      GRP_LDRM: begin
        list[0]  = read_d(ADR_HL);
        list[1]  = fetch_d(XF_MOV8, fy, R8_LATCH, '0);
        list_len = 2'd2;
      end
      GRP_LDMR: begin
        list[0]  = write_d(ADR_HL, XF_MOV8, R8_LATCH, fz);
        list[1]  = plain_fetch();
        list_len = 2'd2;
      end
      GRP_LDRR: list[0] = fetch_d(XF_MOV8, fy, fz, '0);
      GRP_ADDR: list[0] = fetch_d(XF_ADD8, R8_ACC, R8_ACC, fz);
      GRP_ADDM: begin
        list[0]  = read_d(ADR_HL);
        list[1]  = fetch_d(XF_ADD8, R8_ACC, R8_ACC, R8_LATCH);
        list_len = 2'd2;
      end
      GRP_ADDI: begin
        list[0]  = read_d(ADR_PC);
        list[1]  = fetch_d(XF_ADD8, R8_ACC, R8_ACC, R8_LATCH);
        list_len = 2'd2;
      end
      GRP_JUMP: begin
        list[0]  = read_d(ADR_PC);
        list[1]  = read_d(ADR_PC);
        list[2]  = fetch_d(XF_MOV16, R16_PC, R16_LATCH, '0);
        list_len = 2'd3;
      end
      default: unsup = 1'b1;
    endcase
  end

  assign count = CNT_W'(list_len);

  // spread the short list over the parameterised slot array
  for (genvar k = 0; k < MAX_SLOTS; k++) begin : g_slot
    if (k < LIST_N) begin : g_used
      assign slots[k] = list[k];
    end else begin : g_spare
      assign slots[k] = DESC_ZERO;
    end
  end
endmodule

// File: rtl/opcode_mcycle_decoder.sv
module opcode_mcycle_decoder
  import odec_pkg::*;
#(
  parameter int MAX_SLOTS = 5,
  parameter int IDLE_LEN_A = 4,
  parameter int IDLE_LEN_B = 3,
  localparam int CNT_W = $clog2(MAX_SLOTS + 1),
  localparam int FLAT_W = MAX_SLOTS * DESC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        opcode,
  output logic              dec_valid,
  output logic [CNT_W-1:0]  dec_count,
  output logic              dec_unsup,
  output logic              dec_halt,
  output logic [FLAT_W-1:0] dec_slots
);
  logic [1:0] fx;
  logic [2:0] fy;
  logic [2:0] fz;
  logic [1:0] fpair;
  logic       fy_odd;
  grp_e       grp;

  mdesc_t [MAX_SLOTS-1:0] nxt_slots;
  logic   [CNT_W-1:0]     nxt_count;
  logic                   nxt_unsup;
  logic                   nxt_halt;

  odec_fields u_fields (
    .opcode (opcode),
    .fx     (fx),
    .fy     (fy),
    .fz     (fz),
    .fpair  (fpair),
    .fy_odd (fy_odd)
  );

  odec_group u_group (
    .fx     (fx),
    .fy     (fy),
    .fz     (fz),
    .fy_odd (fy_odd),
    .grp    (grp)
  );

  odec_seq #(
    .MAX_SLOTS  (MAX_SLOTS),
    .IDLE_LEN_A (IDLE_LEN_A),
    .IDLE_LEN_B (IDLE_LEN_B)
  ) u_seq (
    .grp   (grp),
    .fy    (fy),
    .fz    (fz),
    .fpair (fpair),
    .slots (nxt_slots),
    .count (nxt_count),
    .unsup (nxt_unsup),
    .halt  (nxt_halt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_count <= '0;
      dec_unsup <= 1'b0;
      dec_halt  <= 1'b0;
    end else begin
      dec_valid <= op_valid;
      if (op_valid) begin
        dec_count <= nxt_count;
        dec_unsup <= nxt_unsup;
        dec_halt  <= nxt_halt;
      end
    end
  end

  for (genvar k = 0; k < MAX_SLOTS; k++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dec_slots[k*DESC_W +: DESC_W] <= '0;
      else if (op_valid) dec_slots[k*DESC_W +: DESC_W] <= nxt_slots[k];
    end
  end
endmodule

// File: rtl/opcode_mcycle_decoder_chk.sv
module opcode_mcycle_decoder_chk #(
  parameter int MAX_SLOTS = 5,
  parameter int DESC_W = 19,
  parameter int CNT_W = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        op_valid,
  input logic                        dec_valid,
  input logic [CNT_W-1:0]            dec_count,
  input logic                        dec_unsup,
  input logic                        dec_halt,
  input logic [MAX_SLOTS*DESC_W-1:0] dec_slots
);
  logic [1:0] last_bus;
  logic       tail_zero;
  logic [DESC_W-1:0] slot0;

  assign slot0 = dec_slots[DESC_W-1:0];

  always_comb begin
    last_bus  = 2'd3;
    tail_zero = 1'b1;
    for (int k = 0; k < MAX_SLOTS; k++) begin
      if (CNT_W'(k + 1) == dec_count) last_bus = dec_slots[k*DESC_W + DESC_W - 1 -: 2];
      if (CNT_W'(k) >= dec_count && dec_slots[k*DESC_W +: DESC_W] != '0) tail_zero = 1'b0;
    end
  end

  // R1
  strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> dec_valid);
  // R1
  idle_to_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !dec_valid);
  // R2
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(dec_slots) && $stable(dec_count) && $stable(dec_unsup) && $stable(dec_halt)));
  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_count >= CNT_W'(1) && dec_count <= CNT_W'(MAX_SLOTS)));
  // R4
  ends_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> last_bus == 2'd0);
  // R4
  spare_slots_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> tail_zero);
  // R5
  unsup_single_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_unsup) |-> (dec_count == CNT_W'(1) && slot0[DESC_W-1 -: 2] == 2'd0 && slot0[11:0] == '0));
  // R9
  halt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_halt |-> (!dec_unsup && dec_count == CNT_W'(1)));
endmodule

bind opcode_mcycle_decoder opcode_mcycle_decoder_chk #(
  .MAX_SLOTS (MAX_SLOTS),
  .DESC_W    (odec_pkg::DESC_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .dec_valid (dec_valid),
  .dec_count (dec_count),
  .dec_unsup (dec_unsup),
  .dec_halt  (dec_halt),
  .dec_slots (dec_slots)
);

// File: tb/opcode_mcycle_decoder_tb_top.sv
`timescale 1ns/1ps
module opcode_mcycle_decoder_tb_top;
  localparam int NS = 5;
  localparam int DW = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic dec_valid, dec_unsup, dec_halt;
  logic [2:0] dec_count;
  logic [NS*DW-1:0] dec_slots;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic exp_valid = 1'b0;
  logic [2:0] exp_count = '0;
  logic exp_unsup = 1'b0, exp_halt = 1'b0;
  logic [NS*DW-1:0] exp_slots = '0;
  string exp_tag = "R3";

  always #10 clk = ~clk;

  opcode_mcycle_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .dec_valid(dec_valid), .dec_count(dec_count), .dec_unsup(dec_unsup),
    .dec_halt(dec_halt), .dec_slots(dec_slots)
  );

  function automatic logic [DW-1:0] mk(int bus, int adr, int len, int op, int dst, int sa, int sb);
    return {bus[1:0], adr[1:0], len[2:0], op[2:0], dst[2:0], sa[2:0], sb[2:0]};
  endfunction

  // behavioural reference: returns list, flags and requirement tag
  task automatic model(input int op, output logic [NS*DW-1:0] flat, output logic [2:0] cnt,
                       output logic un, output logic hl, output string tag);
    logic [DW-1:0] q[$];
    int x, y, z;
    x = op / 64; y = (op / 8) % 8; z = op % 8;
    un = 0; hl = 0; tag = "R5";
    if (op == 0) q.push_back(mk(0,1,0,0,0,0,0));
    else if (x == 0 && z == 6 && y == 6) begin
      tag = "R6"; q.push_back(mk(1,1,0,0,0,0,0)); q.push_back(mk(2,2,0,0,0,0,0)); q.push_back(mk(0,1,0,0,0,0,0));
    end else if (x == 0 && z == 6) begin
      tag = "R6"; q.push_back(mk(1,1,0,0,0,0,0)); q.push_back(mk(0,1,0,1,y,6,0));
    end else if (x == 0 && z == 1 && y % 2 == 0) begin
      tag = "R7"; q.push_back(mk(1,1,0,0,0,0,0)); q.push_back(mk(1,1,0,0,0,0,0)); q.push_back(mk(0,1,0,3,y/2,5,0));
    end else if (x == 0 && z == 1) begin
      tag = "R7"; q.push_back(mk(3,0,4,0,0,0,0)); q.push_back(mk(3,0,3,0,0,0,0)); q.push_back(mk(0,1,0,4,2,2,y/2));
    end else if (op == 'h76) begin
      tag = "R9"; hl = 1; q.push_back(mk(0,1,0,0,0,0,0));
    end else if (x == 1 && z == 6) begin
      tag = "R8"; q.push_back(mk(1,2,0,0,0,0,0)); q.push_back(mk(0,1,0,1,y,6,0));
    end else if (x == 1 && y == 6) begin
      tag = "R8"; q.push_back(mk(2,2,0,1,6,z,0)); q.push_back(mk(0,1,0,0,0,0,0));
    end else if (x == 1) begin
      tag = "R8"; q.push_back(mk(0,1,0,1,y,z,0));
    end else if (x == 2 && y == 0 && z == 6) begin
      tag = "R10"; q.push_back(mk(1,2,0,0,0,0,0)); q.push_back(mk(0,1,0,2,7,7,6));
    end else if (x == 2 && y == 0) begin
      tag = "R10"; q.push_back(mk(0,1,0,2,7,7,z));
    end else if (op == 'hC6) begin
      tag = "R10"; q.push_back(mk(1,1,0,0,0,0,0)); q.push_back(mk(0,1,0,2,7,7,6));
    end else if (op == 'hC3) begin
      tag = "R11"; q.push_back(mk(1,1,0,0,0,0,0)); q.push_back(mk(1,1,0,0,0,0,0)); q.push_back(mk(0,1,0,3,4,5,0));
    end else begin
      un = 1; q.push_back(mk(0,1,0,0,0,0,0));
    end
    flat = '0;
    foreach (q[i]) flat[i*DW +: DW] = q[i];
    cnt = 3'(q.size());
  endtask

  task automatic compare();
    n_checks++;
    if (dec_valid !== exp_valid) begin
      n_fail++; $display("FAIL R1 valid act=%0b exp=%0b", dec_valid, exp_valid);
    end
    n_checks++;
    if (dec_count !== exp_count || dec_unsup !== exp_unsup || dec_halt !== exp_halt || dec_slots !== exp_slots) begin
      n_fail++;
      $display("FAIL %s R4 act=%0d/%0b/%0b/%h exp=%0d/%0b/%0b/%h", exp_tag, dec_count, dec_unsup,
               dec_halt, dec_slots, exp_count, exp_unsup, exp_halt, exp_slots);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] op);
    @(negedge clk);
    compare();
    op_valid = v; opcode = op;
    exp_valid = v;
    if (v) model(int'(op), exp_slots, exp_count, exp_unsup, exp_halt, exp_tag);
    else exp_tag = "R2";
  endtask

  initial begin
    // R3: outputs zero under reset
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    for (int op = 0; op < 256; op++) begin
      step(1'b1, 8'(op));
      if (op % 3 == 2) step(1'b0, 8'(op) ^ 8'h5A);
    end
    step(1'b0, 8'hC3);
    step(1'b0, 8'h76);
    step(1'b1, 8'h76);
    step(1'b1, 8'hC3);
    step(1'b0, 8'h00);
    @(negedge clk); compare();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule